// File: doc/BRIEF.md
# Real-Time Clock Alarm Match and Interrupt Flags

This block watches the seconds, minutes and hours of a running clock, compares them against three programmable alarm bytes, and gathers the alarm match, the periodic tick and the end-of-update event into a latched flag byte. Software reads the alarm bytes, the live time fields and the flag byte through a small register port. The register port is control-plane: it has no valid/ready handshake and no back-pressure. A write lands on the clock edge. A read returns its data combinationally in the same cycle. A read of the flag byte clears the latched flags on that edge.

Any alarm byte whose two top bits are both set becomes a wildcard for its field. An event flag always latches when its event occurs. The enable bits only decide whether a latched flag raises the summary bit and the interrupt line. The time counter, the clock divider and any BCD conversion are outside this block.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset, all three alarm bytes read 0x00, the flag byte reads 0x00 and `irq_o` is low.
- R2: A write with `reg_we` stores `reg_wdata` into the seconds, minutes or hours alarm byte at offsets 1, 3 and 5. Those offsets read back the stored byte. Offsets 0, 2 and 4 read the live seconds, minutes and hours inputs. A write to any other offset changes no alarm byte, and any other offset except 12 reads 0x00.
- R3: An alarm byte with bits 7 and 6 both 1 matches every value of its field. A byte with only one of those bits set is compared exactly.
- R4: The alarm flag (flag byte bit 5) sets on the edge where `upd_done_i` is high and every field either equals its alarm byte or is a wildcard. Without `upd_done_i` the alarm flag never sets.
- R5: The update flag (bit 4) sets on every edge with `upd_done_i` high. The periodic flag (bit 6) sets on every edge with `periodic_i` high.
- R6: Event flags latch regardless of the enables and stay set until the flag byte is read.
- R7: Bit 7 of the flag byte is 1 exactly when some flag in bits 6..4 is set and its enable is set in `ctl_i` at the same bit position. `irq_o` equals bit 7. Bits 3..0 always read 0.
- R8: A read (`reg_re`) at offset 12 returns the current flag byte in the same cycle and clears bits 6..4 on that edge. A read at any other offset clears nothing.
- R9: When an event occurs on the same edge as a clearing read, the flag of that event is set afterwards, and flags without an event are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_i | input | 8 | Current seconds field |
| min_i | input | 8 | Current minutes field |
| hour_i | input | 8 | Current hours field |
| upd_done_i | input | 1 | One-cycle strobe at the end of each time update |
| periodic_i | input | 1 | One-cycle periodic event strobe |
| ctl_i | input | 8 | Control byte; bit 6 periodic enable, bit 5 alarm enable, bit 4 update enable |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (needed for clear-on-read) |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| flags_o | output | 8 | Flag byte: bit 7 summary, 6 periodic, 5 alarm, 4 update |
| irq_o | output | 1 | Active-high interrupt request |

## Verification
The bench builds the block with its defaults: 8-bit fields, 4-bit offsets, three fields and the flag byte at offset 12. With these values the exact top-two-bit wildcard patterns (0x80, 0x40, 0xC0, 0xFF) can be tried against real time values. The whole address space can also be reached, so writes to unused offsets can be shown to be harmless. The bench also drives a read of the flag byte on the same edge as a fresh event, and toggles enables while flags are held, to expose the split between latching and signalling.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  // index of each event inside the three-bit latched flag vector
  localparam int unsigned EV_UPD = 0;
  localparam int unsigned EV_ALM = 1;
  localparam int unsigned EV_PER = 2;
  localparam int unsigned N_EV   = 3;
  // position of the event flags and the summary bit in the flag byte
  localparam int unsigned FLAG_LSB = 4;
  localparam int unsigned SUM_BIT  = 7;
endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int W = 8,
  parameter int N = 3
) (
  input  logic [N*W-1:0] time_flat,
  input  logic [N*W-1:0] alarm_flat,
  output logic           all_hit
);
  logic [N-1:0] hit;

  for (genvar g = 0; g < N; g++) begin : g_field
    logic [W-1:0] a_b, t_b;
    logic         wild;
    assign a_b  = alarm_flat[g*W +: W];
    assign t_b  = time_flat[g*W +: W];
    assign wild = a_b[W-1] & a_b[W-2];
    assign hit[g] = wild | (a_b == t_b);
  end

  assign all_hit = &hit;
endmodule

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs #(
  parameter int W      = 8,
  parameter int ADDR_W = 4,
  parameter int N      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [N*W-1:0]    alarm_flat
);
  logic [W-1:0] alm_q [N];

  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (!rst_n)
        alm_q[i] <= '0;
      else if (we && addr == ADDR_W'(2*i+1))
        alm_q[i] <= wdata;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_flat
    assign alarm_flat[g*W +: W] = alm_q[g];
  end
endmodule

// File: rtl/rtc_flag_reg.sv
module rtc_flag_reg
  import rtc_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_EV-1:0] evt,
  input  logic [N_EV-1:0] ena,
  input  logic            clr,
  output logic [N_EV-1:0] flag_q,
  output logic            summary
);
  // a fresh event overrides a clear on the same edge
  always_ff @(posedge clk) begin
    if (!rst_n)
      flag_q <= '0;
    else
      flag_q <= (clr ? '0 : flag_q) | evt;
  end

  assign summary = |(flag_q & ena);
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_irq_pkg::*;
#(
  parameter int W         = 8,
  parameter int ADDR_W    = 4,
  parameter int N         = 3,
  parameter int FLAG_ADDR = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      sec_i,
  input  logic [W-1:0]      min_i,
  input  logic [W-1:0]      hour_i,
  input  logic              upd_done_i,
  input  logic              periodic_i,
  input  logic [W-1:0]      ctl_i,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  output logic [W-1:0]      flags_o,
  output logic              irq_o
);
  localparam int TW = N * W;

  logic [TW-1:0]   time_flat;
  logic [TW-1:0]   alarm_flat;
  logic            all_hit;
  logic [N_EV-1:0] evt, ena, flag_q;
  logic            summary, clr;

  assign time_flat = {hour_i, min_i, sec_i};

  rtc_alarm_regs #(.W(W), .ADDR_W(ADDR_W), .N(N)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .alarm_flat(alarm_flat)
  );

  rtc_alarm_cmp #(.W(W), .N(N)) u_cmp (
    .time_flat(time_flat), .alarm_flat(alarm_flat), .all_hit(all_hit)
  );

  always_comb begin
    evt         = '0;
    evt[EV_UPD] = upd_done_i;
    evt[EV_ALM] = upd_done_i & all_hit;
    evt[EV_PER] = periodic_i;
  end

  assign ena = ctl_i[FLAG_LSB +: N_EV];
  assign clr = reg_re && (reg_addr == ADDR_W'(FLAG_ADDR));

  rtc_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt), .ena(ena), .clr(clr),
    .flag_q(flag_q), .summary(summary)
  );

  always_comb begin
    flags_o                       = '0;
    flags_o[FLAG_LSB +: N_EV]     = flag_q;
    flags_o[SUM_BIT]              = summary;
  end

  assign irq_o = summary;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(FLAG_ADDR))
      reg_rdata = flags_o;
    for (int i = 0; i < N; i++) begin
      if (reg_addr == ADDR_W'(2*i))
        reg_rdata = time_flat[i*W +: W];
      if (reg_addr == ADDR_W'(2*i+1))
        reg_rdata = alarm_flat[i*W +: W];
    end
  end
endmodule

// File: rtl/rtc_alarm_irq_chk.sv
module rtc_alarm_irq_chk #(
  parameter int W         = 8,
  parameter int ADDR_W    = 4,
  parameter int FLAG_ADDR = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              upd_done_i,
  input logic              periodic_i,
  input logic              reg_re,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [W-1:0]      ctl_i,
  input logic [W-1:0]      flags_o,
  input logic              irq_o
);
  logic rd_flag;
  assign rd_flag = reg_re && (reg_addr == ADDR_W'(FLAG_ADDR));

  // R5
  upd_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done_i |=> flags_o[4]);

  // R5
  per_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    periodic_i |=> flags_o[6]);

  // R4
  alarm_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_done_i |=> !$rose(flags_o[5]));

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_flag && !upd_done_i && !periodic_i) |=> (flags_o[6:4] == 3'b000));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o[5] && !rd_flag) |=> flags_o[5]);

  // R7
  low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags_o[3:0] == 4'b0000);

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((flags_o[6:4] & ctl_i[6:4]) != 3'b000));
endmodule

bind rtc_alarm_irq rtc_alarm_irq_chk #(
  .W(W), .ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_done_i(upd_done_i), .periodic_i(periodic_i),
  .reg_re(reg_re), .reg_addr(reg_addr), .ctl_i(ctl_i),
  .flags_o(flags_o), .irq_o(irq_o)
);

// File: tb/rtc_alarm_irq_bench.sv
module rtc_alarm_irq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sec_i = '0, min_i = '0, hour_i = '0, ctl_i = '0;
  logic       upd_done_i = 1'b0, periodic_i = 1'b0;
  logic       reg_we = 1'b0, reg_re = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata, flags_o;
  logic       irq_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #2 clk = ~clk;

  rtc_alarm_irq u_rtc_alarm_irq (
    .clk(clk), .rst_n(rst_n), .sec_i(sec_i), .min_i(min_i), .hour_i(hour_i),
    .upd_done_i(upd_done_i), .periodic_i(periodic_i), .ctl_i(ctl_i),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flags_o(flags_o), .irq_o(irq_o)
  );

  // {alarm s, alarm m, alarm h, time s, time m, time h, expected alarm flag}
  localparam logic [55:0] VEC [9] = '{
    56'h30_15_08_30_15_08_01,
    56'h30_15_08_31_15_08_00,
    56'hC0_15_08_59_15_08_01,
    56'hC0_C0_C0_12_34_56_01,
    56'h80_00_00_00_00_00_00,
    56'h40_10_10_12_10_10_00,
    56'hFF_22_C5_07_22_13_01,
    56'h00_00_00_00_00_01_00,
    56'h45_C0_23_45_59_22_00
  };

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++; total++;
      $display("FAIL watchdog: act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [7:0] d);
    reg_re = 1'b0; reg_addr = a; #1;
    d = reg_rdata;
  endtask

  task automatic clear_read();
    reg_addr = 4'd12; reg_re = 1'b1;
    step();
    reg_re = 1'b0;
  endtask

  initial begin
    logic [7:0] d;
    #1;
    step(); step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    peek(4'd12, d); check("R1 flags", d, 8'h00);
    check("R1 irq", irq_o, 0);
    peek(4'd1, d); check("R1 alarm s", d, 8'h00);
    peek(4'd5, d); check("R1 alarm h", d, 8'h00);

    // R3 R4 R5 table walk, enables off
    for (int v = 0; v < 9; v++) begin
      wr(4'd1, VEC[v][55:48]);
      wr(4'd3, VEC[v][47:40]);
      wr(4'd5, VEC[v][39:32]);
      sec_i = VEC[v][31:24]; min_i = VEC[v][23:16]; hour_i = VEC[v][15:8];
      upd_done_i = 1'b1;
      step();
      upd_done_i = 1'b0;
      peek(4'd12, d);
      check($sformatf("R3 R4 alarm vec%0d", v), d[5], VEC[v][0]);
      check($sformatf("R5 upd vec%0d", v), d[4], 1);
      check($sformatf("R7 irq off vec%0d", v), irq_o, 0);
      clear_read();
    end

    // R2 register map
    wr(4'd1, 8'h11); wr(4'd3, 8'h22); wr(4'd5, 8'h33);
    sec_i = 8'h44; min_i = 8'h55; hour_i = 8'h66;
    peek(4'd1, d); check("R2 alarm s", d, 8'h11);
    peek(4'd3, d); check("R2 alarm m", d, 8'h22);
    peek(4'd5, d); check("R2 alarm h", d, 8'h33);
    peek(4'd0, d); check("R2 time s", d, 8'h44);
    peek(4'd4, d); check("R2 time h", d, 8'h66);
    wr(4'd6, 8'h99); wr(4'd0, 8'h77);
    peek(4'd6, d); check("R2 unused offset", d, 8'h00);
    peek(4'd1, d); check("R2 alarm s kept", d, 8'h11);
    peek(4'd3, d); check("R2 alarm m kept", d, 8'h22);

    // R4 no strobe, all wildcards
    wr(4'd1, 8'hC0); wr(4'd3, 8'hC0); wr(4'd5, 8'hC0);
    step(); step();
    peek(4'd12, d); check("R4 no strobe", d, 8'h00);

    // R5 periodic flag
    periodic_i = 1'b1; step(); periodic_i = 1'b0;
    peek(4'd12, d); check("R5 periodic", d, 8'h40);

    // R6 held while disabled
    step(); step(); step();
    peek(4'd12, d); check("R6 held", d, 8'h40);
    check("R6 irq off", irq_o, 0);

    // R7 enables
    ctl_i = 8'h20; #1;
    check("R7 wrong enable", irq_o, 0);
    ctl_i = 8'h40; #1;
    peek(4'd12, d); check("R7 summary", d, 8'hC0);
    check("R7 irq", irq_o, 1);

    // R8 other offset does not clear
    reg_re = 1'b1; reg_addr = 4'd1; step(); reg_re = 1'b0;
    peek(4'd12, d); check("R8 other read", d, 8'hC0);

    // R8 clear on read
    reg_addr = 4'd12; reg_re = 1'b1; #1;
    check("R8 read data", reg_rdata, 8'hC0);
    step(); reg_re = 1'b0;
    peek(4'd12, d); check("R8 cleared", d, 8'h00);
    check("R8 irq low", irq_o, 0);

    // R9 collision: read clears upd flag, fresh periodic survives
    upd_done_i = 1'b1; step(); upd_done_i = 1'b0;
    reg_addr = 4'd12; reg_re = 1'b1; periodic_i = 1'b1;
    step();
    reg_re = 1'b0; periodic_i = 1'b0;
    peek(4'd12, d); check("R9 collision", d, 8'hC0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule